// File: doc/BRIEF.md
# SDRAM command protocol monitor

A passive observer for one rank of single-data-rate SDRAM. Every clock it samples the chip-select, row strobe, column strobe, write-enable, A10, bank address and clock-enable pins, decodes the command, and keeps a small model of each bank (idle, open, or closing after an auto-precharge burst). It also models the device's low-power mode as chosen by clock enable. It never drives the bus. When it sees an illegal command or a spacing that breaks a minimum timing, it raises one bit in a sticky error vector and pulses a one-cycle violation strobe.

Timing minimums are given in nanoseconds and converted to clock counts from a clock-period parameter, rounded up. The burst-length and CAS-latency settings come in as configuration pins, so the monitor knows how long each burst occupies the bank. An integrator places it beside a memory controller in simulation or in an emulation build and watches the error vector.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: A cycle with cs_n high is a deselect. It raises no error and changes no bank state, whatever the other command pins carry.
- R2: An activate to a bank that is not idle sets error bit 0. A bank that is open, or waiting out an auto-precharge, is not idle.
- R3: A read or write to a bank that is not open sets error bit 1.
- R4: Auto refresh, mode register set or self-refresh entry while any bank is not idle sets error bit 2.
- R5: A burst stop when no full-page burst is running sets error bit 3. A burst-length code with bit 2 set selects full page. Codes 0 to 3 select lengths 1, 2, 4 and 8.
- R6: A read or write issued fewer than ceil(30 ns / period) cycles after the activate of its bank sets error bit 4.
- R7: An activate, refresh or mode register set issued fewer than ceil(30 ns / period) cycles after a precharge of a bank it needs sets error bit 5. The end of an auto-precharge burst counts as that precharge.
- R8: A precharge that closes an open bank fewer than ceil(60 ns / period) cycles after that bank's activate sets error bit 6.
- R9: An activate fewer than ceil(90 ns / period) cycles after the previous activate of the same bank sets error bit 7.
- R10: An activate fewer than ceil(20 ns / period) cycles after any activate sets error bit 8.
- R11: When clock enable falls, lp_mode becomes 2 (self refresh) if the command is the refresh encoding. Otherwise it becomes 3 (clock suspend) if a burst is running, or 1 (power-down) if not. It returns to 0 (running) when clock enable rises.
- R12: Any command other than no-operation or deselect sampled while clock enable was low on the previous edge sets error bit 9.
- R13: A precharge with A10 high closes all banks. A read or write with A10 high leaves its bank closing until the burst ends. The burst lasts its length in cycles, plus the CAS latency for a read. The bank then turns idle with its precharge timer started.
- R14: Error bits stay set until reset. viol is high for exactly the cycle after each offending command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| a10 | input | 1 | Address bit 10 (all-banks / auto-precharge flag) |
| ba | input | BA_W | Bank address |
| cfg_cl | input | 2 | CAS latency in cycles (2 or 3) |
| cfg_bl | input | 3 | Burst-length code |
| err_sticky | output | NUM_ERR | Sticky error bits, one per rule |
| viol | output | 1 | One-cycle violation strobe |
| lp_mode | output | 2 | Low-power mode: 0 run, 1 power-down, 2 self refresh, 3 clock suspend |

## Verification
The bench targets exact timing boundaries: a spacing one cycle short must set its bit, and the spacing at the limit must set nothing. An off-by-one counter would either flag legal traffic or miss real violations. It checks that auto-precharge closes the bank only after the burst drains. A model that closed it at the command would accept an early refresh, and one that never closed it would flag the next activate as a busy bank. It checks that clock enable falling during a burst yields clock suspend rather than power-down. It also drives long stretches of garbage under a high chip select, where a decoder that ignored chip select would open banks or raise errors.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

  typedef enum logic [3:0] {
    C_DESEL, C_NOP, C_ACT, C_RD, C_WR, C_PRE, C_REF, C_MRS, C_BST
  } cmd_e;

  typedef enum logic [1:0] {
    B_IDLE, B_OPEN, B_APWAIT
  } bank_e;

  localparam logic [1:0] LP_RUN  = 2'd0;
  localparam logic [1:0] LP_PDN  = 2'd1;
  localparam logic [1:0] LP_SREF = 2'd2;
  localparam logic [1:0] LP_SUSP = 2'd3;

  localparam int E_ACT_BUSY = 0;
  localparam int E_RW_IDLE  = 1;
  localparam int E_REF_BUSY = 2;
  localparam int E_STOP     = 3;
  localparam int E_RCD      = 4;
  localparam int E_RP       = 5;
  localparam int E_RAS      = 6;
  localparam int E_RC       = 7;
  localparam int E_RRD      = 8;
  localparam int E_LOWPWR   = 9;
  localparam int NUM_ERR    = 10;

  function automatic int ns2cyc(input int ns, input int per);
    return (ns + per - 1) / per;
  endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_mon_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  always_comb begin
    if (cs_n) cmd = C_DESEL;
    else begin
      case ({ras_n, cas_n, we_n})
        3'b111:  cmd = C_NOP;
        3'b011:  cmd = C_ACT;
        3'b101:  cmd = C_RD;
        3'b100:  cmd = C_WR;
        3'b010:  cmd = C_PRE;
        3'b001:  cmd = C_REF;
        3'b000:  cmd = C_MRS;
        default: cmd = C_BST;
      endcase
    end
  end
endmodule

// File: rtl/sdram_bank_fsm.sv
module sdram_bank_fsm
  import sdram_mon_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          act_i,
  input  logic          pre_i,
  input  logic          rwap_i,
  input  logic          done_i,
  output bank_e         st_o,
  output logic [CW-1:0] since_act_o,
  output logic [CW-1:0] since_pre_o
);
  localparam logic [CW-1:0] CMAX = '1;

  bank_e         st;
  logic [CW-1:0] sa, sp;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= B_IDLE;
      sa <= CMAX;
      sp <= CMAX;
    end else begin
      sa <= (sa == CMAX) ? CMAX : sa + 1'b1;
      sp <= (sp == CMAX) ? CMAX : sp + 1'b1;
      if (pre_i) begin
        st <= B_IDLE;
        sp <= '0;
      end else if (done_i && st == B_APWAIT) begin
        st <= B_IDLE;
        sp <= '0;
      end else if (act_i) begin
        st <= B_OPEN;
        sa <= '0;
      end else if (rwap_i) begin
        st <= B_APWAIT;
      end
    end
  end

  assign st_o        = st;
  assign since_act_o = sa;
  assign since_pre_o = sp;
endmodule

// File: rtl/sdram_burst_track.sv
module sdram_burst_track #(
  parameter int BA_W = 2,
  parameter int LW   = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic            rd_i,
  input  logic [BA_W-1:0] bank_i,
  input  logic [1:0]      cl_i,
  input  logic [2:0]      bl_i,
  input  logic            adv_i,
  input  logic            stop_i,
  output logic            active_o,
  output logic            fp_o,
  output logic            done_o,
  output logic [BA_W-1:0] bank_o
);
  logic [LW-1:0]   left, ld;
  logic            fp;
  logic [BA_W-1:0] bank_q;

  assign ld = (LW'(1) << bl_i[1:0]) + (rd_i ? LW'(cl_i) : LW'(0));

  always_ff @(posedge clk) begin
    if (rst) begin
      left   <= '0;
      fp     <= 1'b0;
      bank_q <= '0;
    end else if (start_i) begin
      left   <= ld;
      fp     <= bl_i[2];
      bank_q <= bank_i;
    end else if (stop_i) begin
      left <= '0;
      fp   <= 1'b0;
    end else if (adv_i && !fp && left != '0) begin
      left <= left - 1'b1;
    end
  end

  assign active_o = fp || (left != '0);
  assign fp_o     = fp;
  assign bank_o   = bank_q;
  assign done_o   = active_o && (start_i || stop_i ||
                    (!fp && left == LW'(1) && adv_i));
endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdram_mon_pkg::*;
#(
  parameter int NUM_BANKS     = 4,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_RCD_NS      = 30,
  parameter int T_RP_NS       = 30,
  parameter int T_RAS_NS      = 60,
  parameter int T_RC_NS       = 90,
  parameter int T_RRD_NS      = 20,
  parameter int MAX_BURST     = 8,
  parameter int MAX_CL        = 3,
  parameter int BA_W          = $clog2(NUM_BANKS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cke,
  input  logic               cs_n,
  input  logic               ras_n,
  input  logic               cas_n,
  input  logic               we_n,
  input  logic               a10,
  input  logic [BA_W-1:0]    ba,
  input  logic [1:0]         cfg_cl,
  input  logic [2:0]         cfg_bl,
  output logic [NUM_ERR-1:0] err_sticky,
  output logic               viol,
  output logic [1:0]         lp_mode
);
  localparam int C_RCD = ns2cyc(T_RCD_NS, CLK_PERIOD_NS);
  localparam int C_RP  = ns2cyc(T_RP_NS,  CLK_PERIOD_NS);
  localparam int C_RAS = ns2cyc(T_RAS_NS, CLK_PERIOD_NS);
  localparam int C_RC  = ns2cyc(T_RC_NS,  CLK_PERIOD_NS);
  localparam int C_RRD = ns2cyc(T_RRD_NS, CLK_PERIOD_NS);
  localparam int C_M1  = (C_RCD > C_RP)  ? C_RCD : C_RP;
  localparam int C_M2  = (C_RAS > C_RC)  ? C_RAS : C_RC;
  localparam int C_M3  = (C_M1 > C_M2)   ? C_M1  : C_M2;
  localparam int C_MAX = (C_M3 > C_RRD)  ? C_M3  : C_RRD;
  localparam int CW    = $clog2(C_MAX + 1) + 1;
  localparam int LW    = $clog2(MAX_BURST + MAX_CL + 1) + 1;
  localparam logic [CW-1:0] CMAX = '1;

  cmd_e            cmd;
  logic            cke_q;
  logic [1:0]      lp_q;
  logic [CW-1:0]   glob_act;
  bank_e           st [NUM_BANKS];
  logic [CW-1:0]   sa [NUM_BANKS];
  logic [CW-1:0]   sp [NUM_BANKS];
  logic [NUM_BANKS-1:0] act_hit, pre_hit, rwap_hit, done_hit;
  logic            rw_ok, stop_ok, is_rw;
  logic            b_active, b_fp, b_done;
  logic [BA_W-1:0] b_bank;
  logic [NUM_ERR-1:0] err_now, err_q;
  logic            viol_q;

  sdram_cmd_decode u_dec (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd)
  );

  assign is_rw   = (cmd == C_RD) || (cmd == C_WR);
  assign rw_ok   = cke_q && is_rw && (st[ba] == B_OPEN);
  assign stop_ok = cke_q && (cmd == C_BST) && b_active && b_fp;

  sdram_burst_track #(.BA_W(BA_W), .LW(LW)) u_burst (
    .clk(clk), .rst(rst), .start_i(rw_ok), .rd_i(cmd == C_RD),
    .bank_i(ba), .cl_i(cfg_cl), .bl_i(cfg_bl), .adv_i(cke_q),
    .stop_i(stop_ok), .active_o(b_active), .fp_o(b_fp),
    .done_o(b_done), .bank_o(b_bank)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    assign act_hit[g]  = cke_q && (cmd == C_ACT) && (ba == BA_W'(g));
    assign pre_hit[g]  = cke_q && (cmd == C_PRE) && (a10 || ba == BA_W'(g));
    assign rwap_hit[g] = rw_ok && a10 && (ba == BA_W'(g));
    assign done_hit[g] = b_done && (b_bank == BA_W'(g));

    sdram_bank_fsm #(.CW(CW)) u_bank (
      .clk(clk), .rst(rst), .act_i(act_hit[g]), .pre_i(pre_hit[g]),
      .rwap_i(rwap_hit[g]), .done_i(done_hit[g]),
      .st_o(st[g]), .since_act_o(sa[g]), .since_pre_o(sp[g])
    );
  end

  always_comb begin
    err_now = '0;
    if (!cke_q) begin
      if (cmd != C_NOP && cmd != C_DESEL) err_now[E_LOWPWR] = 1'b1;
    end else begin
      case (cmd)
        C_ACT: begin
          if (st[ba] != B_IDLE)               err_now[E_ACT_BUSY] = 1'b1;
          if (int'(sp[ba]) + 1 < C_RP)        err_now[E_RP]       = 1'b1;
          if (int'(sa[ba]) + 1 < C_RC)        err_now[E_RC]       = 1'b1;
          if (int'(glob_act) + 1 < C_RRD)     err_now[E_RRD]      = 1'b1;
        end
        C_RD, C_WR: begin
          if (st[ba] != B_OPEN)               err_now[E_RW_IDLE]  = 1'b1;
          else if (int'(sa[ba]) + 1 < C_RCD)  err_now[E_RCD]      = 1'b1;
        end
        C_PRE: begin
          for (int i = 0; i < NUM_BANKS; i++)
            if ((a10 || ba == BA_W'(i)) && st[i] == B_OPEN &&
                int'(sa[i]) + 1 < C_RAS)      err_now[E_RAS]      = 1'b1;
        end
        C_REF, C_MRS: begin
          for (int i = 0; i < NUM_BANKS; i++) begin
            if (st[i] != B_IDLE)              err_now[E_REF_BUSY] = 1'b1;
            if (int'(sp[i]) + 1 < C_RP)       err_now[E_RP]       = 1'b1;
          end
        end
        C_BST: begin
          if (!(b_active && b_fp))            err_now[E_STOP]     = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cke_q    <= 1'b1;
      lp_q     <= LP_RUN;
      glob_act <= CMAX;
      err_q    <= '0;
      viol_q   <= 1'b0;
    end else begin
      cke_q    <= cke;
      glob_act <= (cke_q && cmd == C_ACT) ? '0 :
                  (glob_act == CMAX) ? CMAX : glob_act + 1'b1;
      if (cke_q && !cke)
        lp_q <= (cmd == C_REF) ? LP_SREF : (b_active ? LP_SUSP : LP_PDN);
      else if (!cke_q && cke)
        lp_q <= LP_RUN;
      err_q  <= err_q | err_now;
      viol_q <= |err_now;
    end
  end

  assign err_sticky = err_q;
  assign viol       = viol_q;
  assign lp_mode    = lp_q;
endmodule

// File: rtl/sdram_mon_checker.sv
module sdram_mon_checker #(
  parameter int NE = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          cke,
  input logic          cs_n,
  input logic          viol,
  input logic [NE-1:0] err_sticky,
  input logic [1:0]    lp_mode
);
  a_r1_desel_quiet: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> !viol);

  a_r14_sticky_hold: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((err_sticky & $past(err_sticky)) == $past(err_sticky)));

  a_r14_strobe_sets_bit: assert property (@(posedge clk) disable iff (rst)
    viol |-> (err_sticky != '0));

  a_r11_lowpower_needs_cke_low: assert property (@(posedge clk) disable iff (rst)
    (lp_mode != 2'd0) |-> !$past(cke));

  a_r11_sref_exit_to_run: assert property (@(posedge clk) disable iff (rst)
    (lp_mode == 2'd2) |=> (lp_mode == 2'd2 || lp_mode == 2'd0));
endmodule

bind sdram_cmd_monitor sdram_mon_checker #(.NE(sdram_mon_pkg::NUM_ERR)) u_chk (
  .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .viol(viol),
  .err_sticky(err_sticky), .lp_mode(lp_mode)
);

// File: tb/sdram_cmd_monitor_tb_top.sv
module sdram_cmd_monitor_tb_top;
  localparam logic [2:0] K_NOP = 3'b111, K_ACT = 3'b011, K_RD = 3'b101,
                         K_WR = 3'b100, K_PRE = 3'b010, K_REF = 3'b001,
                         K_BST = 3'b110;

  logic clk = 0, rst = 1, cke = 1, cs_n = 1, ras_n = 1, cas_n = 1, we_n = 1, a10 = 0;
  logic [1:0] ba = 0, cfg_cl = 2, lp_mode;
  logic [2:0] cfg_bl = 0;
  logic [9:0] err_sticky;
  logic viol;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  sdram_cmd_monitor dut_i (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .a10(a10), .ba(ba), .cfg_cl(cfg_cl),
    .cfg_bl(cfg_bl), .err_sticky(err_sticky), .viol(viol), .lp_mode(lp_mode)
  );

  function automatic int eb(input int idx);
    return 1 << idx;
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic issue(input logic [2:0] k, input int b, input logic ap, input logic ke);
    @(negedge clk);
    cs_n = 0; {ras_n, cas_n, we_n} = k; ba = 2'(b); a10 = ap; cke = ke;
    @(posedge clk); #2;
  endtask

  task automatic nop(input int n);
    for (int i = 0; i < n; i++) issue(K_NOP, 0, 0, 1);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; cs_n = 1; cke = 1; {ras_n, cas_n, we_n} = K_NOP;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 0;
  endtask

  initial begin
    #(20 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    int seen;
    seed = $urandom(1234);
    do_reset();
    @(posedge clk); #2;
    chk("R14 reset err", int'(err_sticky), 0);
    chk("R14 reset viol", int'(viol), 0);
    chk("R11 reset mode", int'(lp_mode), 0);

    // R1: garbage under deselect
    seen = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      cs_n = 1; {ras_n, cas_n, we_n} = 3'($urandom); a10 = 1'($urandom); ba = 2'($urandom);
      @(posedge clk); #2;
      if (viol) seen++;
    end
    chk("R1 no strobe", seen, 0);
    chk("R1 no error", int'(err_sticky), 0);
    issue(K_RD, 0, 0, 1);
    chk("R1 bank still idle", int'(err_sticky), eb(1));
    chk("R3 strobe", int'(viol), 1);
    nop(3);
    chk("R14 strobe drops", int'(viol), 0);
    chk("R14 bit held", int'(err_sticky), eb(1));
    do_reset(); nop(1);
    chk("R14 reset clears", int'(err_sticky), 0);

    // R2
    issue(K_ACT, 0, 0, 1); nop(8); issue(K_ACT, 0, 0, 1);
    chk("R2 act busy", int'(err_sticky), eb(0));
    // R3 write to idle
    do_reset(); issue(K_WR, 2, 0, 1);
    chk("R3 write idle", int'(err_sticky), eb(1));
    // R4
    do_reset(); issue(K_ACT, 2, 0, 1); nop(2); issue(K_REF, 0, 0, 1);
    chk("R4 refresh busy", int'(err_sticky), eb(2));
    // R5
    do_reset(); issue(K_BST, 0, 0, 1);
    chk("R5 stray stop", int'(err_sticky), eb(3));
    do_reset(); cfg_bl = 3'b100;
    issue(K_ACT, 0, 0, 1); nop(2); issue(K_RD, 0, 0, 1); nop(1); issue(K_BST, 0, 0, 1);
    chk("R5 full page stop ok", int'(err_sticky), 0);
    cfg_bl = 0;
    // R6
    do_reset(); issue(K_ACT, 0, 0, 1); nop(1); issue(K_RD, 0, 0, 1);
    chk("R6 rcd short", int'(err_sticky), eb(4));
    // R7 and R8 boundaries
    do_reset(); issue(K_ACT, 0, 0, 1); nop(7); issue(K_PRE, 0, 0, 1); nop(1); issue(K_ACT, 0, 0, 1);
    chk("R7 rp short", int'(err_sticky), eb(5));
    do_reset(); issue(K_ACT, 0, 0, 1); nop(5); issue(K_PRE, 0, 0, 1); nop(2); issue(K_ACT, 0, 0, 1);
    chk("R7 rp at limit", int'(err_sticky), 0);
    do_reset(); issue(K_ACT, 0, 0, 1); nop(4); issue(K_PRE, 0, 0, 1);
    chk("R8 ras short", int'(err_sticky), eb(6));
    // R9 via auto-precharge write, BL=1
    do_reset(); issue(K_ACT, 0, 0, 1); nop(2); issue(K_WR, 0, 1, 1); nop(3); issue(K_ACT, 0, 0, 1);
    chk("R9 rc short", int'(err_sticky), eb(7));
    // R10
    do_reset(); issue(K_ACT, 0, 0, 1); issue(K_ACT, 1, 0, 1);
    chk("R10 rrd short", int'(err_sticky), eb(8));
    do_reset(); issue(K_ACT, 0, 0, 1); nop(1); issue(K_ACT, 1, 0, 1);
    chk("R10 rrd at limit", int'(err_sticky), 0);
    // R11
    do_reset(); issue(K_NOP, 0, 0, 0);
    chk("R11 power-down", int'(lp_mode), 1);
    issue(K_NOP, 0, 0, 1);
    chk("R11 wake", int'(lp_mode), 0);
    issue(K_REF, 0, 0, 0);
    chk("R11 self refresh", int'(lp_mode), 2);
    issue(K_NOP, 0, 0, 0); issue(K_NOP, 0, 0, 1);
    chk("R11 sref exit", int'(lp_mode), 0);
    cfg_bl = 3; cfg_cl = 3;
    issue(K_ACT, 0, 0, 1); nop(2); issue(K_RD, 0, 0, 1); issue(K_NOP, 0, 0, 0);
    chk("R11 suspend", int'(lp_mode), 3);
    chk("R11 no error", int'(err_sticky), 0);
    cfg_bl = 0; cfg_cl = 2;
    // R12
    do_reset(); issue(K_NOP, 0, 0, 0); issue(K_ACT, 0, 0, 0);
    chk("R12 cmd in power-down", int'(err_sticky), eb(9));
    chk("R12 strobe", int'(viol), 1);
    // R13 precharge all
    do_reset(); issue(K_ACT, 0, 0, 1); nop(1); issue(K_ACT, 1, 0, 1); nop(7);
    issue(K_PRE, 0, 1, 1); nop(2); issue(K_REF, 0, 0, 1);
    chk("R13 all closed", int'(err_sticky), 0);
    // R13 auto-precharge read, BL=1 CL=2: closes 3 cycles after command
    do_reset(); issue(K_ACT, 3, 0, 1); nop(2); issue(K_RD, 3, 1, 1); nop(1); issue(K_REF, 0, 0, 1);
    chk("R13 still closing", int'(err_sticky), eb(2));
    do_reset(); issue(K_ACT, 3, 0, 1); nop(2); issue(K_RD, 3, 1, 1); nop(5); issue(K_REF, 0, 0, 1);
    chk("R13 closed after burst", int'(err_sticky), 0);

    // random legal traffic
    do_reset();
    for (int it = 0; it < 30; it++) begin
      int b, n;
      cfg_cl = 2'(2 + $urandom % 2);
      cfg_bl = ($urandom % 5 == 0) ? 3'b100 : 3'($urandom % 4);
      b = int'($urandom % 4);
      issue(K_ACT, b, 0, 1);
      nop(2 + int'($urandom % 3));
      n = 1 + int'($urandom % 3);
      for (int j = 0; j < n; j++) begin
        issue(($urandom % 2) ? K_RD : K_WR, b, (j == n - 1) && ($urandom % 2 == 1), 1);
        nop(int'($urandom % 3));
      end
      nop(8);
      issue(K_PRE, b, 1'($urandom), 1);
      nop(14);
    end
    chk("R7 random legal traffic", int'(err_sticky), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule